// File: doc/BRIEF.md
# Serial Flash Page Read Master

This block is the host side of a single-bit serial link to a paged flash memory. A client hands it one request holding a 13-bit page number, an 11-bit starting byte within that page and a byte count. The block selects the flash, sends a command byte, a 24-bit address that packs the page above the byte offset, and four filler bytes. It then clocks in the requested number of bytes and hands each one to a valid/ready stream together with its position inside the page.

The flash returns bytes from the start of the same page after the last byte of that page, so it never moves on to the next page. The master follows that rule: the index it attaches to each byte goes back to zero after the last byte of the page. The serial clock is a divided copy of the system clock. If the consumer of the stream stops accepting bytes, the serial clock pauses before the last bit of a byte is taken in. No byte is dropped and the chip select stays low through the pause.

Top module: `pgrd_master`

## Requirements
- R1: After reset, and whenever no read is in progress, `spi_csn` is 1, `spi_sck` is 0, `out_valid` is 0 and `req_ready` is 1.
- R2: The first byte sent after chip select falls is the command 0x52, or 0xD2 when `alt_opcode` is 1 in the cycle the request is accepted.
- R3: Bytes two to four carry `{req_page[12:0], req_offset[10:0]}` as one 24-bit value, most significant bit first.
- R4: Four bytes of 0x00 follow the address. The first data bit is taken in on the 65th rising edge of `spi_sck`.
- R5: The serial clock follows SPI mode 0. `spi_sck` idles at 0. `spi_mosi` changes only while `spi_sck` is 0. `spi_miso` is sampled on each rising edge. While bytes are flowing, each level of `spi_sck` lasts CLK_DIV system clocks.
- R6: A request with a nonzero count yields exactly `req_count` stream bytes. Each byte is assembled from `spi_miso` most significant bit first, and the frame holds exactly 64 + 8×count rising edges.
- R7: `out_index` starts at `req_offset` and goes up by one per byte. After PAGE_BYTES-1 it goes back to 0, and it is always below PAGE_BYTES.
- R8: `spi_csn` stays 0 without a break from the command through the last data bit. It then rises, and it stays 1 for at least two system clocks before the next frame.
- R9: A request is taken only while `req_ready` is 1, and `req_ready` is 0 for the whole frame. A request with count 0 is taken but starts no frame.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_index` hold their values. The serial clock pauses, so no later byte overwrites a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_opcode | input | 1 | Selects the alternate command value 0xD2 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_page | input | 13 | Page number, 0 to 8191 |
| req_offset | input | 11 | Starting byte within the page |
| req_count | input | 12 | Number of bytes to fetch |
| out_valid | output | 1 | Stream byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Received byte |
| out_index | output | 11 | Page-relative position of the byte |
| spi_csn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The testbench uses a small page of 16 bytes. It sweeps every starting offset with three counts: one byte, a run inside the page, and a run longer than the page. This separates wrap-index errors from plain counting errors. The flash model returns a byte computed from the page and index, so a shifted, reordered or wrongly wrapped byte shows up as a mismatch. The same sweep runs under three consumer patterns: always ready, briefly stalled, and stalled for long stretches. Comparing the three separates the back-pressure pause from the basic data path. The pages at both ends of the page range, both command values, a zero count, and a request raised during a busy frame each have their own cases.

// File: rtl/pgrd_pkg.sv
// Package pgrd_pkg
// Shared constants and types for the serial flash page read master.
// Assumes an 8-bit command and a byte-oriented serial frame.
package pgrd_pkg;

    localparam logic [7:0] OPC_MAIN = 8'h52;
    localparam logic [7:0] OPC_ALT  = 8'hD2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/pgrd_tick.sv
// Module pgrd_tick
// Gives a one-cycle tick every DIV system clocks while enabled. The count
// restarts from zero whenever the enable is low, so the first tick after
// enabling comes exactly DIV cycles later. Assumes DIV >= 1.
module pgrd_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(DIV - 1));

    // Counts system clocks within one half period of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pgrd_shift.sv
// Module pgrd_shift
// Moves one byte at a time in SPI mode 0. The bit on MOSI changes on a
// falling edge or at load, and MISO is taken on each rising edge. The
// byte ends on its eighth falling edge. In that cycle done is raised
// combinationally, so a new byte can be loaded with no gap in the clock.
// When hold is set, the eighth rising edge is held back.
// Assumes load is only raised when idle or in the done cycle.
module pgrd_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       hold,
    input  logic       miso,
    output logic       active,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    logic       act_q;
    logic       sck_q;
    logic [2:0] bit_q;
    logic [7:0] tx_q;
    logic [7:0] rx_q;

    assign active  = act_q;
    assign sck     = sck_q;
    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;
    assign done    = act_q && tick && sck_q && (bit_q == 3'd7);

    // Walks the two clock phases of every bit of the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            sck_q <= 1'b0;
            bit_q <= 3'd0;
            tx_q  <= 8'h00;
            rx_q  <= 8'h00;
        end else if (load) begin
            act_q <= 1'b1;
            sck_q <= 1'b0;
            bit_q <= 3'd0;
            tx_q  <= tx_byte;
        end else if (act_q && tick) begin
            if (!sck_q) begin
                if (!(hold && bit_q == 3'd7)) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso};
                end
            end else begin
                sck_q <= 1'b0;
                if (bit_q == 3'd7) begin
                    act_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    tx_q  <= {tx_q[6:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/pgrd_seq.sv
// Module pgrd_seq
// Frame sequencer. It takes a request, drives chip select, and feeds the
// byte shifter in order: the command, the packed address bytes, the
// filler bytes, then the data bytes. It also keeps the page-relative
// index, which goes back to zero at the end of the page, and holds one
// output byte for the stream.
// Assumes req_offset < PAGE_BYTES and CS_GAP >= 1.
module pgrd_seq
    import pgrd_pkg::*;
#(
    parameter int PAGE_W      = 13,
    parameter int BYTE_W      = 11,
    parameter int CNT_W       = 12,
    parameter int PAGE_BYTES  = 1056,
    parameter int DUMMY_BYTES = 4,
    parameter int CS_GAP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_opcode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [BYTE_W-1:0] req_offset,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              done,
    input  logic [7:0]        rx_byte,
    output logic              load,
    output logic [7:0]        tx_byte,
    output logic              hold,
    output logic              csn,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic [BYTE_W-1:0] out_index
);

    localparam int ADDR_BITS  = PAGE_W + BYTE_W;
    localparam int ADDR_BYTES = (ADDR_BITS + 7) / 8;
    localparam int ADDR_W8    = ADDR_BYTES * 8;
    localparam int HDR_BYTES  = 1 + ADDR_BYTES + DUMMY_BYTES;
    localparam int HW         = $clog2(HDR_BYTES);
    localparam int GW         = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(PAGE_BYTES - 1);

    seq_state_t          state_q;
    logic [ADDR_W8-1:0]  addr_q;
    logic [HW-1:0]       hdr_q;
    logic [HW-1:0]       nxt_hdr;
    logic [CNT_W-1:0]    rem_q;
    logic [BYTE_W-1:0]   idx_q;
    logic [GW-1:0]       gap_q;
    logic                csn_q;
    logic                start;
    logic                hdr_last;
    logic                data_last;

    assign req_ready = (state_q == ST_IDLE);
    assign start     = req_valid && req_ready && (req_count != '0);
    assign nxt_hdr   = hdr_q + 1'b1;
    assign hdr_last  = (hdr_q == HW'(HDR_BYTES - 1));
    assign data_last = (rem_q == CNT_W'(1));
    assign csn       = csn_q;
    assign hold      = out_valid && !out_ready;

    // Raises a byte load at the start of a frame and after each finished byte.
    always_comb begin
        load = start
             || (done && state_q == ST_HDR)
             || (done && state_q == ST_DATA && !data_last);
    end

    // Picks the next byte to send: command, an address byte, or zero filler.
    always_comb begin
        tx_byte = 8'h00;
        if (state_q == ST_IDLE) begin
            tx_byte = alt_opcode ? OPC_ALT : OPC_MAIN;
        end else if (state_q == ST_HDR && int'(nxt_hdr) >= 1
                     && int'(nxt_hdr) <= ADDR_BYTES) begin
            tx_byte = addr_q[8 * (ADDR_BYTES - int'(nxt_hdr)) +: 8];
        end
    end

    // Moves the frame through its phases and keeps the byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            csn_q   <= 1'b1;
            addr_q  <= '0;
            hdr_q   <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
            gap_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_HDR;
                        csn_q   <= 1'b0;
                        hdr_q   <= '0;
                        rem_q   <= req_count;
                        idx_q   <= req_offset;
                        addr_q  <= ADDR_W8'({req_page, req_offset});
                    end
                end
                ST_HDR: begin
                    if (done) begin
                        hdr_q <= nxt_hdr;
                        if (hdr_last) begin
                            state_q <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (done) begin
                        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                        rem_q <= rem_q - 1'b1;
                        if (data_last) begin
                            state_q <= ST_GAP;
                            csn_q   <= 1'b1;
                            gap_q   <= '0;
                        end
                    end
                end
                default: begin
                    if (gap_q == GW'(CS_GAP - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Holds one received byte and its index until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            out_index <= '0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (done && state_q == ST_DATA) begin
                out_valid <= 1'b1;
                out_data  <= rx_byte;
                out_index <= idx_q;
            end
        end
    end

endmodule

// File: rtl/pgrd_master.sv
// Module pgrd_master
// Top of the serial flash page read master. It joins the half-period tick
// generator, the byte shifter and the frame sequencer. Each request gives
// one frame on the serial pins and a run of bytes on the output stream.
// Assumes CLK_DIV >= 1 and req_offset < PAGE_BYTES.
module pgrd_master #(
    parameter int CLK_DIV     = 4,
    parameter int PAGE_W      = 13,
    parameter int BYTE_W      = 11,
    parameter int CNT_W       = 12,
    parameter int PAGE_BYTES  = 1056,
    parameter int DUMMY_BYTES = 4,
    parameter int CS_GAP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_opcode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [BYTE_W-1:0] req_offset,
    input  logic [CNT_W-1:0]  req_count,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic [BYTE_W-1:0] out_index,
    output logic              spi_csn,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic       sh_active;
    logic       sh_tick;
    logic       sh_load;
    logic       sh_done;
    logic       sh_hold;
    logic [7:0] sh_tx;
    logic [7:0] sh_rx;

    pgrd_tick #(
        .DIV (CLK_DIV)
    ) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sh_active),
        .tick  (sh_tick)
    );

    pgrd_shift shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sh_tick),
        .load    (sh_load),
        .tx_byte (sh_tx),
        .hold    (sh_hold),
        .miso    (spi_miso),
        .active  (sh_active),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    pgrd_seq #(
        .PAGE_W      (PAGE_W),
        .BYTE_W      (BYTE_W),
        .CNT_W       (CNT_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .DUMMY_BYTES (DUMMY_BYTES),
        .CS_GAP      (CS_GAP)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alt_opcode (alt_opcode),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_page   (req_page),
        .req_offset (req_offset),
        .req_count  (req_count),
        .done       (sh_done),
        .rx_byte    (sh_rx),
        .load       (sh_load),
        .tx_byte    (sh_tx),
        .hold       (sh_hold),
        .csn        (spi_csn),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_index  (out_index)
    );

endmodule

// File: rtl/pgrd_master_chk.sv
// Module pgrd_master_chk
// Property checker for pgrd_master, attached through bind. It checks the
// pin protocol and the stream rules at the ports only.
module pgrd_master_chk #(
    parameter int BYTE_W     = 11,
    parameter int PAGE_BYTES = 1056
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic [BYTE_W-1:0] out_index,
    input logic              spi_csn,
    input logic              spi_sck,
    input logic              spi_mosi
);

    // R1 and R9: while idle the flash is deselected.
    p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_csn);

    // R5: the serial clock rests low while chip select is high.
    p_sck_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_sck);

    // R5: MOSI does not move while the serial clock is high.
    p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));

    // R7: the index stays inside the page.
    p_index_in_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_index) < PAGE_BYTES));

    // R8: chip select stays high for at least two clocks after it rises.
    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_csn) |=> spi_csn);

    // R10: a pending byte and its index hold until taken.
    p_stream_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_index)));

endmodule

bind pgrd_master pgrd_master_chk #(
    .BYTE_W     (BYTE_W),
    .PAGE_BYTES (PAGE_BYTES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_index (out_index),
    .spi_csn   (spi_csn),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi)
);

// File: tb/pgrd_master_tb_top.sv
// Testbench for pgrd_master: a small page, a computed flash model and
// sweeps over offsets, counts and consumer patterns.
module pgrd_master_tb_top;

    localparam int CLK_DIV    = 2;
    localparam int PAGE_BYTES = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_opcode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [12:0] req_page = '0;
    logic [10:0] req_offset = '0;
    logic [11:0] req_count = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic [10:0] out_index;
    logic        spi_csn;
    logic        spi_sck;
    logic        spi_mosi;
    logic        miso_m = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pgrd_master #(
        .CLK_DIV    (CLK_DIV),
        .PAGE_BYTES (PAGE_BYTES)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alt_opcode (alt_opcode),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_page   (req_page),
        .req_offset (req_offset),
        .req_count  (req_count),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_index  (out_index),
        .spi_csn    (spi_csn),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .spi_miso   (miso_m)
    );

    function automatic logic [7:0] dbyte(int p, int i);
        return 8'((p * 37 + i * 11 + 5) ^ (p >> 5));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0h exp %0h", tag, act, exp);
        end
    endtask

    // Flash model and frame monitors
    int          bitn = 0;
    logic [63:0] hsh = '0;
    int          mpage = 0;
    int          moff = 0;
    int          fcnt = 0;
    int          hi_cnt = 0;
    int          gap_seen = 0;
    int          cyc = 0;
    int          last_rise = 0;
    int          pmin = 0;
    int          pmax = 0;
    logic        sck_prev = 1'b0;
    int          rmode = 0;

    always @(negedge spi_csn) begin
        bitn = 0;
        fcnt++;
        gap_seen = hi_cnt;
        pmin = 9999;
        pmax = 0;
    end

    always @(posedge spi_sck) begin
        if (!spi_csn) begin
            if (bitn < 64) hsh = {hsh[62:0], spi_mosi};
            bitn++;
            if (bitn == 32) begin
                mpage = int'(hsh[23:11]);
                moff  = int'(hsh[10:0]);
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_csn && bitn >= 64) begin
            int k;
            logic [7:0] b;
            k = bitn - 64;
            b = dbyte(mpage, (moff + k / 8) % PAGE_BYTES);
            miso_m = b[7 - (k % 8)];
        end
    end

    always @(posedge clk) begin
        cyc++;
        hi_cnt = spi_csn ? hi_cnt + 1 : 0;
        if (spi_sck && !sck_prev && !spi_csn) begin
            if (bitn >= 2 && bitn <= 64) begin
                if (cyc - last_rise < pmin) pmin = cyc - last_rise;
                if (cyc - last_rise > pmax) pmax = cyc - last_rise;
            end
            last_rise = cyc;
        end
        sck_prev = spi_sck;
    end

    // Consumer ready patterns
    always @(posedge clk) begin
        #1;
        case (rmode)
            0:       out_ready = 1'b1;
            1:       out_ready = (cyc % 3) != 0;
            default: out_ready = (cyc % 48) >= 40;
        endcase
    end

    task automatic run(int page, int off, int cnt, bit alt, int rm, bit poke);
        int got;
        int idx;
        rmode = rm;
        while (!req_ready) @(negedge clk);
        req_page   = 13'(page);
        req_offset = 11'(off);
        req_count  = 12'(cnt);
        alt_opcode = alt;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        alt_opcode = ~alt;
        if (poke) begin
            chk(req_ready == 1'b0, "R9 busy not ready", int'(req_ready), 0);
            req_page   = 13'(page ^ 5);
            req_offset = 11'(off ^ 3);
            req_valid  = 1'b1;
            repeat (20) @(negedge clk);
            chk(req_ready == 1'b0, "R9 busy ignores request", int'(req_ready), 0);
            req_valid = 1'b0;
        end
        got = 0;
        while (got < cnt) begin
            @(negedge clk);
            if (out_valid && out_ready) begin
                idx = (off + got) % PAGE_BYTES;
                chk(out_index == 11'(idx), "R7 index wrap", int'(out_index), idx);
                chk(out_data == dbyte(page, idx), "R6 data byte",
                    int'(out_data), int'(dbyte(page, idx)));
                got++;
            end
        end
        while (!spi_csn) @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 no extra byte", int'(out_valid), 0);
        chk(hsh[63:56] == (alt ? 8'hD2 : 8'h52), "R2 command",
            int'(hsh[63:56]), alt ? 'hD2 : 'h52);
        chk(hsh[55:32] == {13'(page), 11'(off)}, "R3 address",
            int'(hsh[55:32]), int'({13'(page), 11'(off)}));
        chk(hsh[31:0] == 32'h0, "R4 filler bytes", int'(hsh[31:0]), 0);
        chk(bitn == 64 + 8 * cnt, "R8 continuous select bit count", bitn, 64 + 8 * cnt);
        chk(pmin == 2 * CLK_DIV && pmax == 2 * CLK_DIV, "R5 sck period",
            pmax, 2 * CLK_DIV);
        if (fcnt > 1) chk(gap_seen >= 2, "R8 select gap", gap_seen, 2);
    endtask

    initial begin
        int cnts[3];
        int f0;
        cnts[0] = 1;
        cnts[1] = 6;
        cnts[2] = 19;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_csn == 1'b1 && spi_sck == 1'b0, "R1 reset pins",
            int'({spi_csn, spi_sck}), 2);
        chk(out_valid == 1'b0 && req_ready == 1'b1, "R1 reset stream",
            int'({out_valid, req_ready}), 1);

        for (int o = 0; o < PAGE_BYTES; o++) begin
            for (int c = 0; c < 3; c++) begin
                run((o * 523 + c * 97) % 8192, o, cnts[c], 1'((o + c) % 2),
                    (o + c) % 3, 1'b0);
            end
        end
        run(8191, 15, 4, 1'b1, 2, 1'b0);
        run(0, 0, 2, 1'b0, 0, 1'b1);

        // R9: a zero count is taken but starts no frame
        while (!req_ready) @(negedge clk);
        f0 = fcnt;
        req_count = 12'd0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk(fcnt == f0 && spi_csn == 1'b1, "R9 zero count no frame", fcnt, f0);
        chk(out_valid == 1'b0 && req_ready == 1'b1, "R9 zero count idle",
            int'({out_valid, req_ready}), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 act %0d exp done", 200000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule